// File: doc/BRIEF.md
# Equipment Clock Mode Sequencer

This block decides which operating mode an equipment clock generator is in, and it produces the word that steers the local oscillator. Three signals come in. A flag says whether the chosen timing reference is usable. A flag from the phase loop says the loop is in lock. A correction word arrives from the loop filter on every cycle.

The block moves between four modes: free run, acquiring, locked and holdover. While it is acquiring or locked it averages the correction word over fixed windows of 2^N samples. The result of each window becomes the stored holdover word. The block enters holdover only when such a stored word exists. In holdover the stored word steers the oscillator. In free run a fixed nominal word steers it. The output control word never jumps: each cycle it moves toward its current target by a bounded step. This smooths out the frequency steps caused by switching references or modes.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: The mode output uses this encoding: 2'b00 free run, 2'b01 acquiring, 2'b10 locked, 2'b11 holdover. While reset is active and directly after it, the block shows mode 2'b00, `hold_valid` 0 and `ctrl_word` equal to NOMINAL_WORD (default 0).
- R2: In free run, the mode becomes acquiring one clock after `ref_ok` and `lock_ok` are both high. If either of them is low, the block stays in free run.
- R3: In acquiring, `hold_valid` rises on the clock that takes the 2^AVG_LOG2-th consecutive sample, and the mode becomes locked one clock later. If the reference or the lock is lost before that and no valid word exists, the mode returns to free run and the partial window is discarded.
- R4: The stored holdover word equals floor(sum of a window's 2^AVG_LOG2 correction samples / 2^AVG_LOG2). Samples are taken on every clock in acquiring or locked, and each completed window replaces the word. A window cut short by leaving these modes leaves the word unchanged.
- R5: In acquiring or locked, the mode becomes holdover one clock after `ref_ok` or `lock_ok` drops, provided `hold_valid` is 1.
- R6: In holdover, the control target is the stored word. `corr_word` has no effect, and the stored word does not change.
- R7: In holdover, the mode becomes locked one clock after `ref_ok` and `lock_ok` are both high.
- R8: `ctrl_word` moves toward its target by at most STEP (default 1) LSB per clock. The target is `corr_word` in acquiring and locked, and NOMINAL_WORD in free run. The target is taken from the mode held before the clock edge.
- R9: Once set, `hold_valid` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok | input | 1 | Selected reference is usable |
| lock_ok | input | 1 | Phase loop reports lock |
| corr_word | input | CW_W | Per-cycle frequency correction from the loop (unsigned) |
| mode | output | 2 | Current operating mode |
| ctrl_word | output | CW_W | Slew-limited oscillator control word |
| hold_valid | output | 1 | A complete averaged holdover word is stored |

## Verification
The hardest case to set up is a window that stops partway. This happens when acquiring is aborted, or when the reference is lost in the middle of a locked window. To show that such a window changes nothing, the stored word is visible only through `ctrl_word` after the block has settled in holdover. The stimulus first fills a window with a ramp of samples whose mean is known. It then leaves the mode partway through a later window fed with very different samples. It finally waits in holdover until the slew-limited output has converged, and checks that the output equals the earlier mean.

// File: rtl/clkgen_mode_pkg.sv
package clkgen_mode_pkg;
   typedef enum logic [1:0] {
      MODE_FREE = 2'b00,
      MODE_ACQ  = 2'b01,
      MODE_LOCK = 2'b10,
      MODE_HOLD = 2'b11
   } mode_e;
endpackage

// File: rtl/clkgen_mode_fsm.sv
module clkgen_mode_fsm
   import clkgen_mode_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ref_ok,
   input  logic  lock_ok,
   input  logic  hold_valid,
   output mode_e state
);
   logic  ref_good;
   mode_e state_nxt;

   assign ref_good = ref_ok & lock_ok;

   always_comb begin
      state_nxt = state;
      unique case (state)
         MODE_FREE: if (ref_good) state_nxt = MODE_ACQ;
         MODE_ACQ: begin
            if (!ref_good)       state_nxt = hold_valid ? MODE_HOLD : MODE_FREE;
            else if (hold_valid) state_nxt = MODE_LOCK;
         end
         MODE_LOCK: if (!ref_good) state_nxt = hold_valid ? MODE_HOLD : MODE_FREE;
         MODE_HOLD: if (ref_good) state_nxt = MODE_LOCK;
         default:   state_nxt = MODE_FREE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= MODE_FREE;
      else        state <= state_nxt;
   end

   // R2
   free_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == MODE_FREE |=> state inside {MODE_FREE, MODE_ACQ});
   // R5
   hold_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == MODE_HOLD |-> hold_valid);
   // R7
   hold_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MODE_HOLD && ref_ok && lock_ok) |=> state == MODE_LOCK);
   // R3
   acq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MODE_ACQ && ref_ok && lock_ok && hold_valid) |=> state == MODE_LOCK);
endmodule

// File: rtl/clkgen_hold_avg.sv
module clkgen_hold_avg #(
   parameter int CW_W     = 16,
   parameter int AVG_LOG2 = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sample_en,
   input  logic [CW_W-1:0] sample,
   output logic [CW_W-1:0] hold_word,
   output logic            hold_valid
);
   localparam int ACC_W = CW_W + AVG_LOG2;

   generate
      if (AVG_LOG2 < 1 || AVG_LOG2 > 24) begin : g_bad_log2
         $error("clkgen_hold_avg: AVG_LOG2 must lie in 1..24");
      end
      if (CW_W < 2) begin : g_bad_width
         $error("clkgen_hold_avg: CW_W must be at least 2");
      end
   endgenerate

   logic [ACC_W-1:0]    acc;
   logic [ACC_W-1:0]    acc_sum;
   logic [AVG_LOG2-1:0] cnt;
   logic                last;

   assign acc_sum = acc + ACC_W'(sample);
   assign last    = &cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc        <= '0;
         cnt        <= '0;
         hold_word  <= '0;
         hold_valid <= 1'b0;
      end else if (!sample_en) begin
         acc <= '0;
         cnt <= '0;
      end else if (last) begin
         acc        <= '0;
         cnt        <= '0;
         hold_word  <= acc_sum[ACC_W-1:AVG_LOG2];
         hold_valid <= 1'b1;
      end else begin
         acc <= acc_sum;
         cnt <= cnt + 1'b1;
      end
   end

   // R9
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_valid |=> hold_valid);
   // R6
   word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en |=> $stable(hold_word));
endmodule

// File: rtl/clkgen_slew.sv
module clkgen_slew #(
   parameter int          W     = 16,
   parameter int          STEP  = 1,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] target,
   output logic [W-1:0] q
);
   generate
      if (STEP < 0 || STEP >= (1 << (W - 1))) begin : g_bad_step
         $error("clkgen_slew: STEP out of range");
      end

      if (STEP == 0) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) q <= INIT;
            else        q <= target;
         end
      end else begin : g_limited
         localparam logic [W-1:0] STEP_W = W'(STEP);
         logic [W-1:0] q_nxt;

         always_comb begin
            q_nxt = q;
            if (target > q)
               q_nxt = ((target - q) > STEP_W) ? q + STEP_W : target;
            else if (target < q)
               q_nxt = ((q - target) > STEP_W) ? q - STEP_W : target;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) q <= INIT;
            else        q <= q_nxt;
         end

         // R8
         step_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q >= $past(q)) ? ((q - $past(q)) <= STEP_W) : (($past(q) - q) <= STEP_W));
      end
   endgenerate
endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
   import clkgen_mode_pkg::*;
#(
   parameter int              CW_W         = 16,
   parameter int              AVG_LOG2     = 8,
   parameter int              STEP         = 1,
   parameter logic [CW_W-1:0] NOMINAL_WORD = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ref_ok,
   input  logic            lock_ok,
   input  logic [CW_W-1:0] corr_word,
   output logic [1:0]      mode,
   output logic [CW_W-1:0] ctrl_word,
   output logic            hold_valid
);
   mode_e           state;
   logic [CW_W-1:0] hold_word;
   logic [CW_W-1:0] target;
   logic            sample_en;

   assign sample_en = (state == MODE_ACQ) || (state == MODE_LOCK);
   assign mode      = state;

   always_comb begin
      unique case (state)
         MODE_FREE: target = NOMINAL_WORD;
         MODE_HOLD: target = hold_word;
         default:   target = corr_word;
      endcase
   end

   clkgen_mode_fsm i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_ok     (ref_ok),
      .lock_ok    (lock_ok),
      .hold_valid (hold_valid),
      .state      (state)
   );

   clkgen_hold_avg #(
      .CW_W     (CW_W),
      .AVG_LOG2 (AVG_LOG2)
   ) i_avg (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_en  (sample_en),
      .sample     (corr_word),
      .hold_word  (hold_word),
      .hold_valid (hold_valid)
   );

   clkgen_slew #(
      .W    (CW_W),
      .STEP (STEP),
      .INIT (NOMINAL_WORD)
   ) i_slew (
      .clk    (clk),
      .rst_n  (rst_n),
      .target (target),
      .q      (ctrl_word)
   );
endmodule

// File: tb/test_clkgen_mode_ctrl.sv
`timescale 1ns/1ps
module test_clkgen_mode_ctrl;
   localparam int CW_W = 12;
   localparam int LOG2 = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ref_ok = 1'b0;
   logic            lock_ok = 1'b0;
   logic [CW_W-1:0] corr_word = '0;
   logic [1:0]      mode;
   logic [CW_W-1:0] ctrl_word;
   logic            hold_valid;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   clkgen_mode_ctrl #(.CW_W(CW_W), .AVG_LOG2(LOG2), .STEP(1), .NOMINAL_WORD('0))
   i_clkgen_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .lock_ok(lock_ok),
      .corr_word(corr_word), .mode(mode), .ctrl_word(ctrl_word), .hold_valid(hold_valid)
   );

   // ref, lock, corr[12], cycles[8], exp mode[2], exp valid, exp ctrl[12]
   localparam int NV = 13;
   localparam logic [36:0] VEC [NV] = '{
      {1'b0, 1'b0, 12'd50,  8'd3,  2'd0, 1'b0, 12'd0},   // R2 stay free, R8 nominal target
      {1'b1, 1'b0, 12'd50,  8'd3,  2'd0, 1'b0, 12'd0},   // R2 needs both flags
      {1'b1, 1'b1, 12'd50,  8'd1,  2'd1, 1'b0, 12'd0},   // R2 enter acquiring
      {1'b1, 1'b1, 12'd50,  8'd5,  2'd1, 1'b0, 12'd5},   // R8 one LSB per clock
      {1'b0, 1'b1, 12'd50,  8'd1,  2'd0, 1'b0, 12'd6},   // R3 abort to free
      {1'b1, 1'b1, 12'd50,  8'd1,  2'd1, 1'b0, 12'd5},   // R8 back toward nominal
      {1'b1, 1'b1, 12'd50,  8'd16, 2'd1, 1'b1, 12'd21},  // R3 full window
      {1'b1, 1'b1, 12'd50,  8'd1,  2'd2, 1'b1, 12'd22},  // R3 locked
      {1'b1, 1'b1, 12'd50,  8'd40, 2'd2, 1'b1, 12'd50},  // R8 converged on loop word
      {1'b0, 1'b1, 12'd90,  8'd1,  2'd3, 1'b1, 12'd51},  // R5 holdover entry
      {1'b0, 1'b0, 12'd90,  8'd10, 2'd3, 1'b1, 12'd50},  // R6 stored word drives
      {1'b1, 1'b1, 12'd60,  8'd1,  2'd2, 1'b1, 12'd50},  // R7 relock
      {1'b1, 1'b1, 12'd60,  8'd5,  2'd2, 1'b1, 12'd55}   // R8 slew to new loop word
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input logic r, input logic l, input int c);
      ref_ok    = r;
      lock_ok   = l;
      corr_word = CW_W'(c);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      drive(1'b0, 1'b0, 0);
      step(3);
      chk("R1", "mode in reset", mode, 0);
      chk("R1", "valid in reset", hold_valid, 0);
      chk("R1", "ctrl in reset", ctrl_word, 0);
      rst_n = 1'b1;
   endtask

   initial begin
      step(1);
      do_reset();
      step(1);
      chk("R1", "mode after reset", mode, 0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][36], VEC[i][35], int'(VEC[i][34:23]));
         step(int'(VEC[i][22:15]));
         chk($sformatf("vec%0d", i), "mode",  mode,       int'(VEC[i][14:13]));
         chk($sformatf("vec%0d", i), "valid", hold_valid, int'(VEC[i][12]));
         chk($sformatf("vec%0d", i), "ctrl",  ctrl_word,  int'(VEC[i][11:0]));
      end

      // R4 ramp average: samples 100..115 -> floor(1720/16) = 107
      do_reset();
      drive(1'b1, 1'b1, 0);
      step(1);
      chk("R2", "mode acq", mode, 1);
      for (int i = 0; i < 16; i++) begin
         drive(1'b1, 1'b1, 100 + i);
         step(1);
         if (i == 14) chk("R3", "valid before window end", hold_valid, 0);
      end
      chk("R3", "valid at window end", hold_valid, 1);
      drive(1'b0, 1'b1, 107);
      step(1);
      chk("R5", "acq with valid to hold", mode, 3);
      drive(1'b0, 1'b0, 900);
      step(100);
      chk("R4", "ramp mean in hold", ctrl_word, 107);
      chk("R9", "valid held", hold_valid, 1);

      // R4 refresh by a full locked window
      drive(1'b1, 1'b1, 30);
      step(1);
      chk("R7", "relock", mode, 2);
      step(16);
      drive(1'b0, 1'b1, 30);
      step(1);
      chk("R5", "locked to hold", mode, 3);
      step(120);
      chk("R4", "refreshed word", ctrl_word, 30);

      // R4 partial window leaves word unchanged
      drive(1'b1, 1'b1, 200);
      step(11);
      chk("R7", "relock again", mode, 2);
      drive(1'b0, 1'b0, 200);
      step(100);
      chk("R4", "partial window discarded", ctrl_word, 30);
      chk("R6", "still hold", mode, 3);

      // R1 reset mid-operation clears everything
      do_reset();
      step(1);
      chk("R9", "valid cleared only by reset", hold_valid, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule